// File: doc/BRIEF.md
# Mixed-Precision Density Pipeline Dispatcher

This block sits between the proposal stage and the update stage of a parallel-tempering sampler. It takes one stream of density evaluation requests, each tagged with a chain index and a request kind. It spreads them over a bank of density pipelines: one full-precision lane and `N_LO` reduced-precision lanes. Every lane can start a new evaluation only once per `II` cycles. The dispatcher starts lanes as soon as they are able to take work, so three reduced lanes with a six-cycle spacing together absorb one hot-chain request every two cycles on average.

The coldest chain is chain index 0. Its update evaluations must be computed exactly. So must the cold-density term of an exchange between chain 0 and chain 1. Both go to the full-precision lane. All other work goes round-robin to the reduced-precision lanes. Requests are accepted strictly in arrival order. When the lane a request needs cannot start it, the input is held with backpressure. A reorder buffer indexed by issue slot collects the finished values. It hands them to the update stage in issue order, with the original tag. The lanes are latency and spacing models. The full-precision lane passes the sample through unchanged, and a reduced lane clears the low `LO_DROP` bits.

Top module: `tempering_dispatch`

## Requirements
- R1: A request of kind 0 (update) for chain 0, or of kind 1 (cold-density cross term), starts lane 0, the full-precision lane (lane_start bit 0), and its result has res_hi = 1.
- R2: Any other request (kind 0 for chains other than 0, kind 2 hot-density cross term, kind 3) starts a reduced lane. The lane is the first free one found by searching lanes 1..N_LO cyclically, beginning just after the reduced lane granted last, or at lane 1 after reset. Its result has res_hi = 0.
- R3: No lane receives two starts fewer than II cycles apart.
- R4: req_ready is low exactly when the lane class a waiting request needs has no free lane. The request is then held and accepted later, never overtaken; two back-to-back chain-0 updates are accepted exactly II cycles apart.
- R5: Results leave in the order requests were accepted, each carrying its request's chain index and kind.
- R6: A full-precision result equals the request sample. A reduced-precision result equals the sample with its low LO_DROP bits cleared.
- R7: From an idle bank, a continuous stream of 30 hot-chain requests is fully accepted 56 cycles after the first acceptance (three starts per six cycles).
- R8: After reset no result is valid, no lane starts, and every lane is free, so req_ready is high for any request kind.
- R9: Every accepted request yields exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_chain | input | CHAIN_W | Chain index, 0 is the coldest chain |
| req_kind | input | 2 | 0 update, 1 cold-density cross term, 2 hot-density cross term |
| req_sample | input | DATA_W | Sample word to evaluate |
| lane_start | output | N_LO+1 | One bit per lane, set in the cycle that lane is given work; bit 0 is full precision |
| res_valid | output | 1 | Result present, consumed in the same cycle |
| res_chain | output | CHAIN_W | Chain index of the result |
| res_kind | output | 2 | Kind of the result |
| res_hi | output | 1 | Result came from the full-precision lane |
| res_value | output | DATA_W | Evaluated value |

## Verification
Embedded properties watch, on every cycle, the lane spacing, the routing of cold work to lane 0 and hot work away from it, the single start per cycle, the stall when lane 0 is busy, and the reorder buffer's slot bookkeeping and occupancy. Only the bench's scenarios show the rest. These are the cyclic order of the reduced-lane grants, the exact acceptance cycles under a saturating stream, the order, tags and truncated values of the returned results, and that nothing is lost or duplicated after a mixed random run.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
   localparam logic [1:0] KIND_UPD   = 2'd0;
   localparam logic [1:0] KIND_XCOLD = 2'd1;
   localparam logic [1:0] KIND_XHOT  = 2'd2;

   function automatic logic wants_full(input logic [1:0] kind, input logic chain_is_zero);
      return ((kind == KIND_UPD) && chain_is_zero) || (kind == KIND_XCOLD);
   endfunction
endpackage

// File: rtl/tdisp_lane.sv
module tdisp_lane #(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 4,
   parameter int LAT    = 8,
   parameter int II     = 6,
   parameter int DROP   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   input  logic [TAG_W-1:0]  in_tag,
   output logic              free,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data,
   output logic [TAG_W-1:0]  out_tag
);
   localparam int CNT_W = $clog2(II + 1);

   logic [CNT_W-1:0]  busy_q;
   logic [CNT_W-1:0]  gap_q;
   logic [DATA_W-1:0] shaped;
   logic [LAT-1:0]    v_q;
   logic [DATA_W-1:0] d_q [LAT];
   logic [TAG_W-1:0]  t_q [LAT];

   generate
      if (DROP == 0) begin : g_full
         assign shaped = in_data;
      end else begin : g_trunc
         assign shaped = {in_data[DATA_W-1:DROP], {DROP{1'b0}}};
      end
   endgenerate

   assign free = (busy_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
         gap_q  <= CNT_W'(II);
         v_q    <= '0;
      end else begin
         if (in_vld)
            busy_q <= CNT_W'(II - 1);
         else if (busy_q != '0)
            busy_q <= busy_q - 1'b1;
         if (in_vld)
            gap_q <= '0;
         else if (gap_q < CNT_W'(II))
            gap_q <= gap_q + 1'b1;
         v_q <= {v_q[LAT-2:0], in_vld};
      end
   end

   always_ff @(posedge clk) begin
      d_q[0] <= shaped;
      t_q[0] <= in_tag;
      for (int s = 1; s < LAT; s++) begin
         d_q[s] <= d_q[s-1];
         t_q[s] <= t_q[s-1];
      end
   end

   assign out_vld  = v_q[LAT-1];
   assign out_data = d_q[LAT-1];
   assign out_tag  = t_q[LAT-1];

   // R3
   lane_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> (gap_q >= CNT_W'(II - 1)));

   // R4
   accept_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> free);
endmodule

// File: rtl/tdisp_rr_pick.sv
module tdisp_rr_pick #(
   parameter int N     = 3,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     free,
   input  logic [IDX_W-1:0] ptr,
   output logic [N-1:0]     gnt,
   output logic             any,
   output logic [IDX_W-1:0] gnt_idx
);
   always_comb begin
      gnt     = '0;
      any     = 1'b0;
      gnt_idx = '0;
      for (int off = 0; off < N; off++) begin
         automatic int idx = (int'(ptr) + off) % N;
         if (!any && free[idx]) begin
            any      = 1'b1;
            gnt[idx] = 1'b1;
            gnt_idx  = IDX_W'(idx);
         end
      end
   end
endmodule

// File: rtl/tdisp_rob.sv
module tdisp_rob #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 16,
   parameter int META_W = 12,
   parameter int NW     = 4,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc,
   input  logic [META_W-1:0]    alloc_meta,
   output logic [IDX_W-1:0]     alloc_idx,
   output logic                 full,
   input  logic [NW-1:0]        wr_vld,
   input  logic [NW*IDX_W-1:0]  wr_idx,
   input  logic [NW*DATA_W-1:0] wr_data,
   output logic                 out_vld,
   output logic [META_W-1:0]    out_meta,
   output logic [DATA_W-1:0]    out_data
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [IDX_W-1:0]  wr_q, rd_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DEPTH-1:0]  held_q, done_q;
   logic [META_W-1:0] meta_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic              pop;

   assign alloc_idx = wr_q;
   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign out_vld   = done_q[rd_q];
   assign out_meta  = meta_q[rd_q];
   assign out_data  = data_q[rd_q];
   assign pop       = out_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= '0;
         rd_q   <= '0;
         cnt_q  <= '0;
         held_q <= '0;
         done_q <= '0;
      end else begin
         if (alloc) begin
            wr_q         <= wr_q + 1'b1;
            held_q[wr_q] <= 1'b1;
         end
         for (int w = 0; w < NW; w++)
            if (wr_vld[w]) done_q[wr_idx[w*IDX_W +: IDX_W]] <= 1'b1;
         if (pop) begin
            rd_q         <= rd_q + 1'b1;
            held_q[rd_q] <= 1'b0;
            done_q[rd_q] <= 1'b0;
         end
         cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (alloc) meta_q[wr_q] <= alloc_meta;
      for (int w = 0; w < NW; w++)
         if (wr_vld[w]) data_q[wr_idx[w*IDX_W +: IDX_W]] <= wr_data[w*DATA_W +: DATA_W];
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (cnt_q < CNT_W'(DEPTH)));

   generate
      for (genvar gw = 0; gw < NW; gw++) begin : g_slot_chk
         // R5
         rob_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_vld[gw] |-> (held_q[wr_idx[gw*IDX_W +: IDX_W]] && !done_q[wr_idx[gw*IDX_W +: IDX_W]]));
      end
   endgenerate
endmodule

// File: rtl/tempering_dispatch.sv
module tempering_dispatch
   import tdisp_pkg::*;
#(
   parameter int CHAIN_W   = 9,
   parameter int DATA_W    = 16,
   parameter int N_LO      = 3,
   parameter int II        = 6,
   parameter int HI_LAT    = 12,
   parameter int LO_LAT    = 7,
   parameter int LO_DROP   = 8,
   parameter int ROB_DEPTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [CHAIN_W-1:0] req_chain,
   input  logic [1:0]         req_kind,
   input  logic [DATA_W-1:0]  req_sample,
   output logic [N_LO:0]      lane_start,
   output logic               res_valid,
   output logic [CHAIN_W-1:0] res_chain,
   output logic [1:0]         res_kind,
   output logic               res_hi,
   output logic [DATA_W-1:0]  res_value
);
   localparam int NL       = N_LO + 1;
   localparam int TAG_W    = $clog2(ROB_DEPTH);
   localparam int LO_IDX_W = (N_LO > 1) ? $clog2(N_LO) : 1;
   localparam int META_W   = CHAIN_W + 3;

   generate
      if (N_LO < 1) begin : g_bad_nlo
         $error("N_LO must be at least 1");
      end
      if (II < 1) begin : g_bad_ii
         $error("II must be at least 1");
      end
      if (HI_LAT < 2 || LO_LAT < 2) begin : g_bad_lat
         $error("lane latency must be at least 2");
      end
      if (LO_DROP < 0 || LO_DROP >= DATA_W) begin : g_bad_drop
         $error("LO_DROP must lie in 0..DATA_W-1");
      end
      if (ROB_DEPTH < 2 || (ROB_DEPTH & (ROB_DEPTH - 1)) != 0) begin : g_bad_rob
         $error("ROB_DEPTH must be a power of two");
      end
   endgenerate

   logic                  need_hi;
   logic                  fire;
   logic                  rob_full;
   logic [TAG_W-1:0]      slot;
   logic [N_LO-1:0]       lo_free, lo_gnt;
   logic                  lo_any;
   logic [LO_IDX_W-1:0]   lo_idx, rr_q;
   logic [NL-1:0]         lane_free, lane_ov;
   logic [NL*DATA_W-1:0]  lane_od;
   logic [NL*TAG_W-1:0]   lane_ot;
   logic [META_W-1:0]     head_meta;

   assign need_hi   = wants_full(req_kind, req_chain == '0);
   assign lo_free   = lane_free[NL-1:1];
   assign req_ready = !rob_full && (need_hi ? lane_free[0] : lo_any);
   assign fire      = req_valid && req_ready;

   assign lane_start[0] = fire && need_hi;
   assign lane_start[NL-1:1] = (fire && !need_hi) ? lo_gnt : '0;

   tdisp_rr_pick #(.N(N_LO), .IDX_W(LO_IDX_W)) u_pick (
      .free(lo_free), .ptr(rr_q), .gnt(lo_gnt), .any(lo_any), .gnt_idx(lo_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rr_q <= '0;
      else if (fire && !need_hi)
         rr_q <= (lo_idx == LO_IDX_W'(N_LO - 1)) ? '0 : lo_idx + 1'b1;
   end

   generate
      for (genvar gl = 0; gl < NL; gl++) begin : g_lane
         tdisp_lane #(
            .DATA_W(DATA_W), .TAG_W(TAG_W),
            .LAT((gl == 0) ? HI_LAT : LO_LAT), .II(II),
            .DROP((gl == 0) ? 0 : LO_DROP)
         ) u_lane (
            .clk(clk), .rst_n(rst_n),
            .in_vld(lane_start[gl]), .in_data(req_sample), .in_tag(slot),
            .free(lane_free[gl]), .out_vld(lane_ov[gl]),
            .out_data(lane_od[gl*DATA_W +: DATA_W]),
            .out_tag(lane_ot[gl*TAG_W +: TAG_W])
         );
      end
   endgenerate

   tdisp_rob #(.DEPTH(ROB_DEPTH), .DATA_W(DATA_W), .META_W(META_W), .NW(NL), .IDX_W(TAG_W)) u_rob (
      .clk(clk), .rst_n(rst_n),
      .alloc(fire), .alloc_meta({need_hi, req_kind, req_chain}),
      .alloc_idx(slot), .full(rob_full),
      .wr_vld(lane_ov), .wr_idx(lane_ot), .wr_data(lane_od),
      .out_vld(res_valid), .out_meta(head_meta), .out_data(res_value)
   );

   assign res_chain = head_meta[CHAIN_W-1:0];
   assign res_kind  = head_meta[CHAIN_W+1:CHAIN_W];
   assign res_hi    = head_meta[CHAIN_W+2];

   // R1
   hi_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && need_hi) |-> (lane_start[0] && lane_start[NL-1:1] == '0));

   // R2
   lo_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_start[NL-1:1] != '0) |-> !need_hi);

   // R3
   start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_start));

   // R4
   hi_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && need_hi && !lane_free[0]) |-> !req_ready);
endmodule

// File: tb/tb_tempering_dispatch.sv
module tb_tempering_dispatch;
   localparam int CHAIN_W = 9;
   localparam int DATA_W  = 16;
   localparam int N_LO    = 3;
   localparam int II      = 6;
   localparam int LO_DROP = 8;
   localparam int NL      = N_LO + 1;

   typedef struct packed {
      logic [CHAIN_W-1:0] chain;
      logic [1:0]         kind;
      logic               hi;
      logic [DATA_W-1:0]  value;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [CHAIN_W-1:0] req_chain = '0;
   logic [1:0] req_kind = 2'd0;
   logic [DATA_W-1:0] req_sample = '0;
   logic [N_LO:0] lane_start;
   logic res_valid;
   logic [CHAIN_W-1:0] res_chain;
   logic [1:0] res_kind;
   logic res_hi;
   logic [DATA_W-1:0] res_value;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int n_acc = 0;
   int n_res = 0;
   int last_m [NL];
   int seen_last [NL];
   int rr_m = 0;
   bit finished = 0;
   exp_t q [$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tempering_dispatch dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_chain(req_chain), .req_kind(req_kind), .req_sample(req_sample),
      .lane_start(lane_start), .res_valid(res_valid), .res_chain(res_chain),
      .res_kind(res_kind), .res_hi(res_hi), .res_value(res_value)
   );

   function automatic bit needs_full(input logic [1:0] k, input logic [CHAIN_W-1:0] ch);
      return (k == 2'd0 && ch == '0) || (k == 2'd1);
   endfunction

   function automatic logic [DATA_W-1:0] shape(input bit hi, input logic [DATA_W-1:0] s);
      return hi ? s : {s[DATA_W-1:LO_DROP], {LO_DROP{1'b0}}};
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   initial begin
      for (int l = 0; l < NL; l++) begin
         last_m[l] = -1000;
         seen_last[l] = -1000;
      end
   end

   // reference model and scoreboard, sampled between edges
   always @(negedge clk) begin
      if (rst_n) begin
         for (int l = 0; l < NL; l++) begin
            if (lane_start[l]) begin
               chk(cyc - seen_last[l] >= II, "R3", "lane start spacing", cyc - seen_last[l], II);
               seen_last[l] = cyc;
            end
         end
         if (req_valid) begin
            automatic bit nh = needs_full(req_kind, req_chain);
            automatic bit er = 0;
            automatic int el = -1;
            if (nh) begin
               er = (cyc - last_m[0]) >= II;
               el = 0;
            end else begin
               for (int off = 0; off < N_LO; off++) begin
                  automatic int idx = (rr_m + off) % N_LO;
                  if (!er && (cyc - last_m[1 + idx]) >= II) begin
                     er = 1;
                     el = 1 + idx;
                  end
               end
            end
            chk(req_ready == er, "R4", "req_ready", req_ready, er);
            if (req_ready && er) begin
               chk(lane_start == (NL)'(1 << el), nh ? "R1" : "R2", "lane_start", lane_start, 1 << el);
               last_m[el] = cyc;
               if (!nh) rr_m = el % N_LO;
               q.push_back('{chain: req_chain, kind: req_kind, hi: nh, value: shape(nh, req_sample)});
               n_acc++;
            end
         end
         if (res_valid) begin
            n_res++;
            if (q.size() == 0) begin
               chk(0, "R9", "result without request", n_res, n_acc);
            end else begin
               automatic exp_t e = q.pop_front();
               chk(res_chain == e.chain && res_kind == e.kind, "R5", "result tag order", {res_chain, res_kind}, {e.chain, e.kind});
               chk(res_hi == e.hi, e.hi ? "R1" : "R2", "result precision", res_hi, e.hi);
               chk(res_value == e.value, "R6", "result value", res_value, e.value);
            end
         end
      end
   end

   task automatic idle(input int n);
      req_valid = 1'b0;
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic send(input int ch, input logic [1:0] k, input logic [DATA_W-1:0] s, output int acc);
      bit done = 0;
      req_valid  = 1'b1;
      req_chain  = CHAIN_W'(ch);
      req_kind   = k;
      req_sample = s;
      while (!done) begin
         @(negedge clk);
         if (req_ready) begin
            done = 1;
            acc  = cyc;
         end
         @(posedge clk);
         #1;
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "R9", "watchdog expired", cyc, 200000);
      finish_run();
   end

   initial begin
      int t0, t1, t2, ta;
      void'($urandom(32'h5eed_1234));
      repeat (5) @(posedge clk);
      #1;
      // R8: reset state observed before reset is released
      @(negedge clk);
      chk(res_valid == 1'b0, "R8", "res_valid in reset", res_valid, 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      req_chain = 3;
      req_kind = 2'd0;
      @(negedge clk);
      chk(res_valid == 1'b0, "R8", "res_valid after reset", res_valid, 0);
      chk(lane_start == '0, "R8", "lane_start after reset", lane_start, 0);
      chk(req_ready == 1'b1, "R8", "ready for hot work", req_ready, 1);
      req_chain = 0;
      #1;
      chk(req_ready == 1'b1, "R8", "ready for cold work", req_ready, 1);
      @(posedge clk);
      #1;

      // R7: saturating hot stream
      idle(8);
      for (int n = 0; n < 30; n++) begin
         send(5 + n, 2'd0, DATA_W'(16'h1357 * (n + 1)), ta);
         if (n == 0) t0 = ta;
      end
      chk(ta - t0 == 56, "R7", "cycles for 30 hot requests", ta - t0, 56);

      // R4: cold updates back to back, then cold cross term
      idle(8);
      send(0, 2'd0, 16'hABCD, t0);
      send(0, 2'd0, 16'h1234, t1);
      send(1, 2'd1, 16'h5A5A, t2);
      chk(t1 - t0 == II, "R4", "second cold update spacing", t1 - t0, II);
      chk(t2 - t1 == II, "R1", "cold cross term spacing", t2 - t1, II);

      // R1 R2: exchange pair, hot term goes to a reduced lane at once
      send(1, 2'd2, 16'hFFFF, ta);
      chk(ta - t2 == 1, "R2", "hot cross term not blocked by cold lane", ta - t2, 1);
      idle(3);

      // R5: ordered sweep over all chains, twice, with exchanges interleaved
      for (int pass = 0; pass < 2; pass++) begin
         for (int c = 0; c < 24; c++) begin
            send(c, 2'd0, DATA_W'(c * 977 + pass), ta);
            if (c % 8 == 7) begin
               send(1, 2'd1, DATA_W'(c + 16'h4000), ta);
               send(0, 2'd2, DATA_W'(c + 16'h8000), ta);
            end
         end
      end

      // random mix
      for (int n = 0; n < 300; n++) begin
         automatic int g = $urandom_range(0, 3);
         automatic int k = $urandom_range(0, 3);
         automatic int c = $urandom_range(0, 7);
         if (g == 0) idle($urandom_range(1, 4));
         send(c, 2'(k), DATA_W'($urandom), ta);
      end

      idle(40);
      chk(q.size() == 0, "R9", "outstanding results", q.size(), 0);
      chk(n_res == n_acc, "R9", "result count", n_res, n_acc);
      finish_run();
   end
endmodule